// File: doc/BRIEF.md
# TMDS Link Rate Mode Controller

This block sits beside the analog front end of a TMDS link repeater. It runs on a fixed reference clock and counts how many periods of the recovered TMDS clock fall inside a fixed gate window. From that count it works out the link bit rate, with a multiplier of 10 or 40 chosen by a clock-ratio flag. From the rate it settles four control outputs that drive the equalizer, PLL and line drivers:
- the operating mode (redriver or retimer), switched with hysteresis;
- the transmit termination code, picked from three rate bands when the strap selects automatic termination;
- a standby flag, raised when no valid clock is present;
- a lock-ready flag, raised once an acquisition interval has passed.

The TMDS clock enters as a toggle level that changes once per TMDS clock period. It passes through a synchronizer before its edges are counted. Each window produces a verdict made of three parts: clock valid, mode, and termination band. A verdict is committed only when two windows in a row agree. The enable pin is synchronized in two stages. While it is low, the block holds power-down and clears all of its state.

Top module: `tmds_rate_ctrl`

## Requirements
- R1: The rate is derived from the number of `tmds_tgl` level changes counted in a gate window of GATE_CYC reference cycles. With the default settings the count equals the TMDS clock in MHz. The bit rate in Mbps is that frequency times 10 when `ratio_quad`=0 and times 40 when `ratio_quad`=1.
- R2: A clock is valid when its frequency lies between 25 and 340 MHz, both limits included. A clock outside that range, or no clock at all, is treated as invalid.
- R3: `mode_o` is encoded 01 for redriver and 10 for retimer. The block moves to retimer when the rate is above 1125 Mbps and back to redriver when the rate is below 875 Mbps. A rate from 875 to 1125 Mbps, or an invalid clock, keeps the committed mode. After enable the mode is redriver.
- R4: In automatic termination, `term_o` is 10 (75–150 Ω) above 3400 Mbps, 01 (150–300 Ω) from 2000 to 3400 Mbps inclusive, and 00 (none) below 2000 Mbps or with an invalid clock. The value 11 never appears.
- R5: `term_strap` encoding: 00 (pin low) forces `term_o`=10, 01 (pin high) forces `term_o`=00, and 1x (floating) selects the automatic choice. The strap takes effect without waiting for a window.
- R6: `standby_o` is 1 while `sig_det_en`=1 and the committed verdict has no valid clock. It is always 0 when `sig_det_en`=0.
- R7: `lock_o` rises exactly ACQ_CYC cycles after a commit that makes the clock valid or changes the mode. It is 0 on the cycle of a mode change and whenever the committed clock is invalid.
- R8: A verdict from a single window that disagrees with both of its neighbours changes no output. Mode and band change only in the cycle after a window closes.
- R9: While the synchronized `en_pin` is low, `mode_o`=00, `term_o`=00 and `standby_o`=`lock_o`=0, and all state is cleared. After the pin returns high, the block restarts as if from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Operation enable; low holds power-down and clears state |
| sig_det_en | input | 1 | Enables standby entry on a missing clock |
| term_strap | input | 2 | Termination strap: 00 low, 01 high, 1x floating |
| tmds_tgl | input | 1 | Level that toggles once per TMDS clock period |
| ratio_quad | input | 1 | Clock-to-bit ratio: 0 gives ×10, 1 gives ×40 |
| mode_o | output | 2 | 00 power-down, 01 redriver, 10 retimer |
| term_o | output | 2 | 00 none, 01 150–300 Ω, 10 75–150 Ω |
| standby_o | output | 1 | Standby request |
| lock_o | output | 1 | Acquisition complete |

## Verification
The bench keeps the default reference scaling (REF_KHZ = 1,000,000, GATE_CYC = 1000), so each window count equals the TMDS frequency in MHz. It shortens ACQ_CYC to 300. Toggle half-periods that divide 1000 give exact counts in every window, whatever the phase. This makes the 25 MHz and 2000 Mbps band edges, the hysteresis hold at 1000 Mbps, and both ratio settings reachable with a simple arithmetic model in the bench. The short acquisition value lets the bench check the lock delay cycle by cycle and repeat it after each mode change.

// File: rtl/tmds_rate_pkg.sv
package tmds_rate_pkg;

  typedef enum logic [1:0] {
    LINK_PDN   = 2'b00,
    LINK_REDRV = 2'b01,
    LINK_RETIM = 2'b10
  } link_mode_e;

  typedef enum logic [1:0] {
    TERM_OPEN   = 2'b00,
    TERM_MID    = 2'b01,
    TERM_STRONG = 2'b10
  } term_e;

  typedef struct packed {
    logic  valid;
    logic  retime;
    term_e band;
  } verdict_t;

  // count * ref_khz is the TMDS frequency in kHz scaled by the gate length
  function automatic logic [63:0] freq_metric(input logic [31:0] cnt,
                                              input int unsigned ref_khz);
    return 64'(cnt) * 64'(ref_khz);
  endfunction

  // same scale, multiplied to a bit rate
  function automatic logic [63:0] rate_metric(input logic [31:0] cnt,
                                              input logic quad,
                                              input int unsigned ref_khz);
    return freq_metric(cnt, ref_khz) * (quad ? 64'd40 : 64'd10);
  endfunction

  // a limit in MHz or Mbps on the scale of the metrics above
  function automatic logic [63:0] limit_metric(input int unsigned value,
                                               input int unsigned gate);
    return 64'(value) * 64'd1000 * 64'(gate);
  endfunction

endpackage

// File: rtl/tmds_sync_bit.sv
module tmds_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tmds_freq_window.sv
module tmds_freq_window #(
  parameter int GATE_CYC = 1000,
  localparam int GW      = $clog2(GATE_CYC),
  localparam int CNT_W   = $clog2(GATE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             lvl_i,
  output logic             win_done_o,
  output logic [CNT_W-1:0] win_count_o
);
  logic             prev_q;
  logic             edge_w;
  logic [GW-1:0]    gate_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_w      = lvl_i ^ prev_q;
  assign win_done_o  = !clr_i && (gate_q == GW'(GATE_CYC - 1));
  assign win_count_o = cnt_q + CNT_W'(edge_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      gate_q <= '0;
      cnt_q  <= '0;
    end else if (win_done_o) begin
      gate_q <= '0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_q + 1'b1;
      cnt_q  <= win_count_o;
    end
  end
endmodule

// File: rtl/tmds_rate_judge.sv
module tmds_rate_judge
  import tmds_rate_pkg::*;
#(
  parameter int unsigned REF_KHZ   = 1000000,
  parameter int unsigned GATE_CYC  = 1000,
  parameter int unsigned ACQ_CYC   = 180000,
  parameter int unsigned XOVER_MBPS = 1000,
  parameter int unsigned HYST_MBPS = 250,
  parameter int unsigned MID_MBPS  = 2000,
  parameter int unsigned HIGH_MBPS = 3400,
  parameter int unsigned FMIN_MHZ  = 25,
  parameter int unsigned FMAX_MHZ  = 340,
  localparam int CNT_W = $clog2(GATE_CYC + 1),
  localparam int ACQ_W = $clog2(ACQ_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             win_done_i,
  input  logic [CNT_W-1:0] win_count_i,
  input  logic             quad_i,
  output verdict_t         cm_o,
  output logic             commit_o,
  output logic             acq_done_o
);
  localparam logic [63:0] UP_TH   = limit_metric(XOVER_MBPS + HYST_MBPS / 2, GATE_CYC);
  localparam logic [63:0] DN_TH   = limit_metric(XOVER_MBPS - HYST_MBPS / 2, GATE_CYC);
  localparam logic [63:0] MID_TH  = limit_metric(MID_MBPS, GATE_CYC);
  localparam logic [63:0] HIGH_TH = limit_metric(HIGH_MBPS, GATE_CYC);
  localparam logic [63:0] FMIN_TH = limit_metric(FMIN_MHZ, GATE_CYC);
  localparam logic [63:0] FMAX_TH = limit_metric(FMAX_MHZ, GATE_CYC);

  verdict_t          cm_q, last_q, v_w;
  logic [ACQ_W-1:0]  acq_q;
  logic [63:0]       f_w, r_w;
  logic              restart_w;

  always_comb begin
    f_w      = freq_metric(32'(win_count_i), REF_KHZ);
    r_w      = rate_metric(32'(win_count_i), quad_i, REF_KHZ);
    v_w.valid = (f_w >= FMIN_TH) && (f_w <= FMAX_TH);
    if (!v_w.valid)     v_w.retime = cm_q.retime;
    else if (cm_q.retime) v_w.retime = !(r_w < DN_TH);
    else                v_w.retime = (r_w > UP_TH);
    if (!v_w.valid)          v_w.band = TERM_OPEN;
    else if (r_w > HIGH_TH)  v_w.band = TERM_STRONG;
    else if (r_w >= MID_TH)  v_w.band = TERM_MID;
    else                     v_w.band = TERM_OPEN;
  end

  assign commit_o   = win_done_i && (v_w == last_q);
  assign restart_w  = commit_o && ((v_w.valid && !cm_q.valid) || (v_w.retime != cm_q.retime));
  assign cm_o       = cm_q;
  assign acq_done_o = cm_q.valid && (acq_q == ACQ_W'(ACQ_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_q   <= '{valid: 1'b0, retime: 1'b0, band: TERM_OPEN};
      last_q <= '{valid: 1'b0, retime: 1'b0, band: TERM_OPEN};
    end else if (clr_i) begin
      cm_q   <= '{valid: 1'b0, retime: 1'b0, band: TERM_OPEN};
      last_q <= '{valid: 1'b0, retime: 1'b0, band: TERM_OPEN};
    end else if (win_done_i) begin
      last_q <= v_w;
      if (commit_o) cm_q <= v_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  acq_q <= '0;
    else if (clr_i || restart_w)                 acq_q <= '0;
    else if (cm_q.valid && acq_q != ACQ_W'(ACQ_CYC)) acq_q <= acq_q + 1'b1;
  end
endmodule

// File: rtl/tmds_rate_ctrl.sv
module tmds_rate_ctrl
  import tmds_rate_pkg::*;
#(
  parameter int unsigned REF_KHZ    = 1000000,
  parameter int unsigned GATE_CYC   = 1000,
  parameter int unsigned ACQ_CYC    = 180000,
  parameter int unsigned XOVER_MBPS = 1000,
  parameter int unsigned HYST_MBPS  = 250,
  parameter int unsigned MID_MBPS   = 2000,
  parameter int unsigned HIGH_MBPS  = 3400,
  parameter int unsigned FMIN_MHZ   = 25,
  parameter int unsigned FMAX_MHZ   = 340,
  parameter int          SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(GATE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       sig_det_en,
  input  logic [1:0] term_strap,
  input  logic       tmds_tgl,
  input  logic       ratio_quad,
  output logic [1:0] mode_o,
  output logic [1:0] term_o,
  output logic       standby_o,
  output logic       lock_o
);
  logic             en_act;
  logic             tgl_sync;
  logic             win_done;
  logic [CNT_W-1:0] win_count;
  logic             commit;
  logic             acq_done;
  verdict_t         cm;
  term_e            term_w;

  tmds_sync_bit #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d_i(en_pin), .q_o(en_act));

  tmds_sync_bit #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(tmds_tgl), .q_o(tgl_sync));

  tmds_freq_window #(.GATE_CYC(GATE_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .clr_i(!en_act), .lvl_i(tgl_sync),
    .win_done_o(win_done), .win_count_o(win_count));

  tmds_rate_judge #(
    .REF_KHZ(REF_KHZ), .GATE_CYC(GATE_CYC), .ACQ_CYC(ACQ_CYC),
    .XOVER_MBPS(XOVER_MBPS), .HYST_MBPS(HYST_MBPS), .MID_MBPS(MID_MBPS),
    .HIGH_MBPS(HIGH_MBPS), .FMIN_MHZ(FMIN_MHZ), .FMAX_MHZ(FMAX_MHZ)
  ) u_judge (
    .clk(clk), .rst_n(rst_n), .clr_i(!en_act), .win_done_i(win_done),
    .win_count_i(win_count), .quad_i(ratio_quad), .cm_o(cm),
    .commit_o(commit), .acq_done_o(acq_done));

  always_comb begin
    unique case (term_strap)
      2'b00:   term_w = TERM_STRONG;
      2'b01:   term_w = TERM_OPEN;
      default: term_w = cm.band;
    endcase
  end

  assign mode_o    = !en_act ? LINK_PDN : (cm.retime ? LINK_RETIM : LINK_REDRV);
  assign term_o    = en_act ? term_w : TERM_OPEN;
  assign standby_o = en_act && sig_det_en && !cm.valid;
  assign lock_o    = en_act && acq_done;
endmodule

// File: rtl/tmds_rate_ctrl_chk.sv
module tmds_rate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_pin,
  input logic       sig_det_en,
  input logic [1:0] mode_o,
  input logic [1:0] term_o,
  input logic       standby_o,
  input logic       lock_o,
  input logic       en_act,
  input logic       win_done
);
  p_pdn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_pin && !$past(en_pin) && !$past(en_pin, 2)) |->
      (mode_o == 2'b00 && term_o == 2'b00 && !standby_o && !lock_o));

  p_term_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    term_o != 2'b11);

  p_no_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det_en |-> !standby_o);

  p_mode_on_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && $past(en_act) && mode_o != $past(mode_o)) |-> $past(win_done));

  p_restart_on_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && $past(en_act) && mode_o != $past(mode_o)) |-> !lock_o);

  p_lock_needs_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (!standby_o && mode_o != 2'b00));
endmodule

bind tmds_rate_ctrl tmds_rate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .sig_det_en(sig_det_en),
  .mode_o(mode_o), .term_o(term_o), .standby_o(standby_o), .lock_o(lock_o),
  .en_act(en_act), .win_done(win_done));

// File: tb/tb_tmds_rate_ctrl.sv
module tb_tmds_rate_ctrl;
  localparam int ACQ = 300;
  localparam int SETTLE = 3400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b1;
  logic sig_det_en = 1'b1;
  logic [1:0] term_strap = 2'b10;
  logic tmds_tgl = 1'b0;
  logic ratio_quad = 1'b0;
  logic [1:0] mode_o, term_o;
  logic standby_o, lock_o;

  int total = 0;
  int bad = 0;
  int half = 0;
  bit finished = 0;
  logic [1:0] m_mode = 2'b01;

  always #10 clk = ~clk;

  tmds_rate_ctrl #(.ACQ_CYC(ACQ)) dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .sig_det_en(sig_det_en),
    .term_strap(term_strap), .tmds_tgl(tmds_tgl), .ratio_quad(ratio_quad),
    .mode_o(mode_o), .term_o(term_o), .standby_o(standby_o), .lock_o(lock_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // TMDS toggle generator: one level change every half reference cycles
  initial begin
    forever begin
      if (half == 0) @(negedge clk);
      else begin
        repeat (half) @(negedge clk);
        tmds_tgl = ~tmds_tgl;
      end
    end
  end

  // arithmetic model of the steady-state verdict for half-period h
  function automatic bit m_valid(input int h);
    return (h != 0) && (h * 25 <= 1000) && (h * 340 >= 1000);
  endfunction

  function automatic int m_rate(input int h, input logic q);
    return (q ? 40000 : 10000) / h;
  endfunction

  function automatic int m_band(input int h, input logic q);
    if (!m_valid(h)) return 0;
    if (m_rate(h, q) > 3400) return 2;
    if (m_rate(h, q) >= 2000) return 1;
    return 0;
  endfunction

  task automatic step_model(input int h, input logic q);
    if (m_valid(h)) begin
      if (m_rate(h, q) > 1125) m_mode = 2'b10;
      else if (m_rate(h, q) < 875) m_mode = 2'b01;
    end
  endtask

  task automatic check_steady(input int h, input logic q);
    chk("R1/R3 mode", int'(mode_o), int'(m_mode));
    chk("R4 term band", int'(term_o), m_band(h, q));
    chk("R2/R6 standby", int'(standby_o), m_valid(h) ? 0 : 1);
    chk("R7 lock", int'(lock_o), m_valid(h) ? 1 : 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sweep[10] = '{2, 4, 5, 8, 10, 20, 25, 40, 50, 0};
    int seen;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // reset state
    chk("R9 initial redriver", int'(mode_o), 1);
    chk("R6 standby at start", int'(standby_o), 1);
    chk("R7 no lock at start", int'(lock_o), 0);
    chk("R4 open at start", int'(term_o), 0);

    // sweep over toggle periods and both ratios
    for (int qi = 0; qi < 2; qi++) begin
      ratio_quad = qi[0];
      foreach (sweep[i]) begin
        half = sweep[i];
        tick(SETTLE);
        step_model(sweep[i], qi[0]);
        check_steady(sweep[i], qi[0]);
      end
    end

    // signal detect disabled: standby never
    sig_det_en = 1'b0;
    tick(2);
    chk("R6 standby off without detect", int'(standby_o), 0);
    chk("R7 no lock without clock", int'(lock_o), 0);
    sig_det_en = 1'b1;
    tick(2);
    chk("R6 standby back with detect", int'(standby_o), 1);

    // exact acquisition delay after a valid commit
    ratio_quad = 1'b0;
    half = 20;
    seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      tick(1);
      if (!standby_o) seen = 1;
    end
    chk("R7 valid commit seen", seen, 1);
    tick(ACQ - 1);
    chk("R7 lock low one cycle early", int'(lock_o), 0);
    tick(1);
    chk("R7 lock high after interval", int'(lock_o), 1);
    chk("R3 redriver at 500 Mbps", int'(mode_o), 1);

    // mode change restarts acquisition
    half = 8;
    seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      tick(1);
      if (mode_o == 2'b10) seen = 1;
    end
    chk("R3 retimer at 1250 Mbps", seen, 1);
    chk("R7 lock cleared at mode change", int'(lock_o), 0);
    tick(ACQ + 20);
    chk("R7 lock after restart", int'(lock_o), 1);

    // strap overrides at 2500 Mbps (auto band 01)
    half = 4;
    tick(SETTLE);
    term_strap = 2'b00; tick(2);
    chk("R5 strap low forces 10", int'(term_o), 2);
    term_strap = 2'b01; tick(2);
    chk("R5 strap high forces 00", int'(term_o), 0);
    term_strap = 2'b11; tick(2);
    chk("R5 strap 11 auto", int'(term_o), 1);
    term_strap = 2'b10; tick(2);
    chk("R5 strap 10 auto", int'(term_o), 1);

    // a single aberrant window is ignored
    half = 20;
    tick(SETTLE);
    chk("R3 settled redriver", int'(mode_o), 1);
    seen = 0;
    half = 2;
    for (int k = 0; k < 200; k++) begin tick(1); if (mode_o != 2'b01) seen++; end
    half = 20;
    for (int k = 0; k < 3200; k++) begin tick(1); if (mode_o != 2'b01) seen++; end
    chk("R8 burst left mode alone", seen, 0);
    chk("R8 lock kept through burst", int'(lock_o), 1);

    // enable low clears state
    half = 8;
    tick(SETTLE);
    chk("R3 retimer before disable", int'(mode_o), 2);
    en_pin = 1'b0;
    tick(5);
    chk("R9 power-down mode", int'(mode_o), 0);
    chk("R9 power-down term", int'(term_o), 0);
    chk("R9 power-down standby", int'(standby_o), 0);
    chk("R9 power-down lock", int'(lock_o), 0);
    en_pin = 1'b1;
    tick(5);
    chk("R9 restart redriver", int'(mode_o), 1);
    chk("R9 restart no lock", int'(lock_o), 0);
    chk("R9 restart standby", int'(standby_o), 1);
    tick(SETTLE);
    chk("R9 retimer regained", int'(mode_o), 2);
    chk("R9 lock regained", int'(lock_o), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule